// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Flag

This block sits next to an asynchronous serial receiver and its receive FIFO. It raises a data-ready flag when characters are still sitting in the FIFO but fewer of them than the receive trigger level, and the line has then stayed quiet for a fixed idle time. This covers the case where a short burst never reaches the trigger level and so would never raise the threshold request by itself. The flag can drive an interrupt request directly.

The idle time is counted in bit-time ticks from the most recent received stop bit. The default is fifteen ticks, which is one and a half frames of an 8-data-bit, 1-stop-bit character. The flag is held at zero while the receiver runs in clocked synchronous mode. The flag can be cleared in two ways. Software can read the flag as 1, drain the FIFO, and then write 0. Alternatively, a DMA transfer started by the FIFO-full request clears the flag once it has emptied the FIFO.

Top module: `rxq_idle_flag`

## Requirements
- R1: After reset `flag_o` and `reg_rdata_o` are 0.
- R2: In asynchronous mode (`sync_mode_i` = 0) with 0 < `fill_cnt_i` < `trig_lvl_i`, the flag becomes 1 on the clock edge after the edge that takes the 15th `bit_tick_i` following the last `stop_bit_i`. After 14 ticks the flag is still 0.
- R3: A `stop_bit_i` pulse restarts the idle count from zero.
- R4: The idle count saturates at 15 and does not wrap. After any number of further ticks, a later qualifying fill level sets the flag on the next edge.
- R5: The flag does not set while `fill_cnt_i` is 0 or while `fill_cnt_i` is at least `trig_lvl_i`.
- R6: While `sync_mode_i` = 1 (clocked synchronous mode) the flag never sets.
- R7: `reg_rdata_o` always shows the current flag value.
- R8: A register write with `reg_wdata_i` = 1 leaves the flag unchanged. A write of 0 that has no earlier register read returning 1 since the last write also leaves the flag unchanged.
- R9: A register read that returns 1 arms an acknowledge, and the next register write consumes it. If that write carries 0 and `fifo_empty_i` = 1, the flag is 0 after that edge. If the FIFO is not empty, the flag stays 1.
- R10: While the flag is 1, `dma_done_i` = 1 together with `fifo_empty_i` = 1 clears the flag on that edge. `dma_done_i` with a non-empty FIFO does not clear it.
- R11: A new character (stop-bit pulse with data in the FIFO) arriving while the flag is 1 does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| sync_mode_i | input | 1 | 1 = clocked synchronous mode, 0 = asynchronous |
| stop_bit_i | input | 1 | One-cycle pulse at each received stop bit |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| fill_cnt_i | input | CNT_W (5) | Entries currently in the receive FIFO |
| trig_lvl_i | input | CNT_W (5) | Programmed receive trigger level |
| fifo_empty_i | input | 1 | Receive FIFO empty |
| dma_done_i | input | 1 | FIFO-full-started DMA transfer is reading out the FIFO |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 1 | Register write data for the flag bit |
| reg_rdata_o | output | 1 | Register read data (flag) |
| flag_o | output | 1 | Data-ready flag / interrupt request |

## Verification
The assertions assume that the inputs are consistent with one another. `fifo_empty_i` is high exactly when `fill_cnt_i` is zero, and stop-bit, tick and register strobes are single-cycle pulses. Without this, a set condition and a clear condition could both be true in the same cycle, and the rules about what may cause a rise or a fall would not hold. The bench changes the fill level only through one task that drives the empty status from the same value. It also issues every strobe as a one-cycle pulse driven on the falling edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic {
      RXQ_MODE_ASYNC = 1'b0,
      RXQ_MODE_SYNC  = 1'b1
   } rxq_mode_e;

   typedef struct packed {
      logic sw;
      logic dma;
   } rxq_clr_t;

endpackage

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
   parameter int IDLE_BITS = 15,
   parameter int TMR_W     = $clog2(IDLE_BITS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic tick_i,
   output logic expired_o
);

   localparam logic [TMR_W-1:0] LIMIT = TMR_W'(IDLE_BITS);

   logic [TMR_W-1:0] cnt_q;

   generate
      if (IDLE_BITS < 1) begin : g_bad_idle
         $error("IDLE_BITS must be at least 1");
      end
      if ((1 << TMR_W) <= IDLE_BITS) begin : g_bad_tmr
         $error("TMR_W too narrow for IDLE_BITS");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = (cnt_q == LIMIT);

   // R3: a stop pulse restarts the count
   p_restart_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == '0));

   // R4: once at the limit, further ticks keep it there
   p_saturate_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && tick_i && !restart_i) |=> expired_o);

   // R4: never beyond the limit
   p_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIMIT);

   // R2: the count only moves on a tick
   p_step_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!restart_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rxq_level_gate.sv
module rxq_level_gate #(
   parameter int CNT_W = 5
) (
   input  logic             sync_mode_i,
   input  logic [CNT_W-1:0] fill_cnt_i,
   input  logic [CNT_W-1:0] trig_lvl_i,
   input  logic             expired_i,
   output logic             set_o
);
   import rxq_pkg::*;

   rxq_mode_e mode;
   logic      has_data;
   logic      below_trig;

   assign mode       = rxq_mode_e'(sync_mode_i);
   assign has_data   = (fill_cnt_i != '0);
   assign below_trig = (fill_cnt_i < trig_lvl_i);

   always_comb begin
      set_o = 1'b0;
      if (mode == RXQ_MODE_ASYNC) begin
         set_o = expired_i && has_data && below_trig;
      end
   end

   // R6: no set request in synchronous mode
   always_comb begin
      if (sync_mode_i) begin
         a_sync_quiet_r6 : assert (!set_o);
      end
   end

endmodule

// File: rtl/rxq_ack_arm.sv
module rxq_ack_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   input  logic reg_rd_i,
   input  logic reg_wr_i,
   input  logic reg_wdata_i,
   input  logic fifo_empty_i,
   output logic sw_clr_o
);

   logic arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
      end else if (reg_wr_i || !flag_i) begin
         arm_q <= 1'b0;
      end else if (reg_rd_i) begin
         arm_q <= 1'b1;
      end
   end

   assign sw_clr_o = reg_wr_i && !reg_wdata_i && arm_q && fifo_empty_i;

   // R9: a write always consumes the acknowledge
   p_arm_consumed_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_i |=> !arm_q);

   // R8: the acknowledge can only be armed by a read of a set flag
   p_arm_src_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm_q) |-> $past(reg_rd_i && flag_i));

endmodule

// File: rtl/rxq_idle_flag.sv
module rxq_idle_flag #(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
   parameter int IDLE_BITS  = 15,
   parameter bit SET_WINS   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_mode_i,
   input  logic             stop_bit_i,
   input  logic             bit_tick_i,
   input  logic [CNT_W-1:0] fill_cnt_i,
   input  logic [CNT_W-1:0] trig_lvl_i,
   input  logic             fifo_empty_i,
   input  logic             dma_done_i,
   input  logic             reg_rd_i,
   input  logic             reg_wr_i,
   input  logic             reg_wdata_i,
   output logic             reg_rdata_o,
   output logic             flag_o
);
   import rxq_pkg::*;

   generate
      if (FIFO_DEPTH < 1) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 1");
      end
      if ((1 << CNT_W) <= FIFO_DEPTH) begin : g_bad_cnt
         $error("CNT_W too narrow for FIFO_DEPTH");
      end
   endgenerate

   logic     expired;
   logic     set_req;
   logic     flag_q;
   logic     flag_d;
   rxq_clr_t clr;

   rxq_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (stop_bit_i),
      .tick_i    (bit_tick_i),
      .expired_o (expired)
   );

   rxq_level_gate #(.CNT_W(CNT_W)) u_gate (
      .sync_mode_i (sync_mode_i),
      .fill_cnt_i  (fill_cnt_i),
      .trig_lvl_i  (trig_lvl_i),
      .expired_i   (expired),
      .set_o       (set_req)
   );

   rxq_ack_arm u_ack (
      .clk          (clk),
      .rst_n        (rst_n),
      .flag_i       (flag_q),
      .reg_rd_i     (reg_rd_i),
      .reg_wr_i     (reg_wr_i),
      .reg_wdata_i  (reg_wdata_i),
      .fifo_empty_i (fifo_empty_i),
      .sw_clr_o     (clr.sw)
   );

   assign clr.dma = dma_done_i && fifo_empty_i;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb begin
            flag_d = flag_q;
            if (set_req) begin
               flag_d = 1'b1;
            end else if (clr.sw || clr.dma) begin
               flag_d = 1'b0;
            end
         end
      end else begin : g_clr_first
         always_comb begin
            flag_d = flag_q;
            if (clr.sw || clr.dma) begin
               flag_d = 1'b0;
            end else if (set_req) begin
               flag_d = 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= flag_d;
      end
   end

   assign flag_o      = flag_q;
   assign reg_rdata_o = flag_q;

   // R6: a rise never follows a cycle in synchronous mode
   p_no_sync_set_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> !$past(sync_mode_i));

   // R5: a rise needs data below the trigger level
   p_set_level_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past((fill_cnt_i != '0) && (fill_cnt_i < trig_lvl_i)));

   // R9 / R10: a fall needs an empty FIFO
   p_clr_drained_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(fifo_empty_i));

   // R8: a write of 1 leaves a set flag set
   p_w1_keep_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && reg_wr_i && reg_wdata_i && !dma_done_i) |=> flag_q);

   // R11: a new stop bit with data present never clears the flag
   p_char_keep_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && stop_bit_i && !fifo_empty_i) |=> flag_q);

endmodule

// File: tb/rxq_idle_flag_tb_top.sv
module rxq_idle_flag_tb_top;

   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          sync_mode_i;
   logic          stop_bit_i;
   logic          bit_tick_i;
   logic [CW-1:0] fill_cnt_i;
   logic [CW-1:0] trig_lvl_i;
   logic          fifo_empty_i;
   logic          dma_done_i;
   logic          reg_rd_i;
   logic          reg_wr_i;
   logic          reg_wdata_i;
   logic          reg_rdata_o;
   logic          flag_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rxq_idle_flag dut_i (
      .clk (clk), .rst_n (rst_n), .sync_mode_i (sync_mode_i),
      .stop_bit_i (stop_bit_i), .bit_tick_i (bit_tick_i),
      .fill_cnt_i (fill_cnt_i), .trig_lvl_i (trig_lvl_i),
      .fifo_empty_i (fifo_empty_i), .dma_done_i (dma_done_i),
      .reg_rd_i (reg_rd_i), .reg_wr_i (reg_wr_i), .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o), .flag_o (flag_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic set_fill(input int n);
      fill_cnt_i   = CW'(n);
      fifo_empty_i = (n == 0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick_i = 1'b1; cyc(); bit_tick_i = 1'b0;
      end
   endtask

   task automatic stop_pulse();
      stop_bit_i = 1'b1; cyc(); stop_bit_i = 1'b0;
   endtask

   task automatic rd_pulse();
      reg_rd_i = 1'b1; cyc(); reg_rd_i = 1'b0;
   endtask

   task automatic wr_pulse(input logic d);
      reg_wr_i = 1'b1; reg_wdata_i = d; cyc(); reg_wr_i = 1'b0; reg_wdata_i = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; sync_mode_i = 1'b0; stop_bit_i = 1'b0; bit_tick_i = 1'b0;
      trig_lvl_i = CW'(8); set_fill(0); dma_done_i = 1'b0;
      reg_rd_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = 1'b0;
      cyc(); cyc(); rst_n = 1'b1; cyc();
   endtask

   task automatic make_set();
      set_fill(2); stop_pulse(); ticks(15); cyc();
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 flag after reset", flag_o, 1'b0);
      check("R1 rdata after reset", reg_rdata_o, 1'b0);
   endtask

   task automatic t_basic();
      do_reset();
      set_fill(3); stop_pulse(); ticks(14); cyc();
      check("R2 no set after 14 ticks", flag_o, 1'b0);
      ticks(1); check("R2 not yet on 15th tick edge", flag_o, 1'b0);
      cyc();
      check("R2 set after 15 ticks", flag_o, 1'b1);
      check("R7 rdata mirrors flag", reg_rdata_o, 1'b1);
   endtask

   task automatic t_restart();
      do_reset();
      set_fill(1); stop_pulse(); ticks(10);
      set_fill(2); stop_pulse(); ticks(10); cyc();
      check("R3 restarted count not expired", flag_o, 1'b0);
      ticks(5); cyc();
      check("R3 set 15 ticks after latest stop", flag_o, 1'b1);
   endtask

   task automatic t_saturate();
      do_reset();
      stop_pulse(); ticks(20); cyc();
      check("R5 no set with empty FIFO", flag_o, 1'b0);
      set_fill(1); cyc();
      check("R4 count held at limit", flag_o, 1'b1);
   endtask

   task automatic t_level();
      do_reset();
      trig_lvl_i = CW'(4); set_fill(4); stop_pulse(); ticks(18); cyc();
      check("R5 no set at trigger level", flag_o, 1'b0);
      set_fill(6); cyc();
      check("R5 no set above trigger level", flag_o, 1'b0);
      set_fill(3); cyc();
      check("R5 set below trigger level", flag_o, 1'b1);
   endtask

   task automatic t_sync();
      do_reset();
      sync_mode_i = 1'b1; set_fill(2); stop_pulse(); ticks(20); cyc(); cyc();
      check("R6 no set in sync mode", flag_o, 1'b0);
      sync_mode_i = 1'b0; cyc();
      check("R6 set once back in async mode", flag_o, 1'b1);
   endtask

   task automatic t_sw_clear();
      do_reset();
      make_set();
      set_fill(0);
      wr_pulse(1'b0);
      check("R8 write 0 without read ignored", flag_o, 1'b1);
      rd_pulse(); wr_pulse(1'b1);
      check("R8 write 1 ignored", flag_o, 1'b1);
      wr_pulse(1'b0);
      check("R8 ack consumed by earlier write", flag_o, 1'b1);
      rd_pulse(); set_fill(2); wr_pulse(1'b0);
      check("R9 no clear while FIFO holds data", flag_o, 1'b1);
      set_fill(0); rd_pulse(); wr_pulse(1'b0);
      check("R9 read 1 then write 0 when drained", flag_o, 1'b0);
      check("R7 rdata follows clear", reg_rdata_o, 1'b0);
   endtask

   task automatic t_dma();
      do_reset();
      make_set();
      dma_done_i = 1'b1; cyc();
      check("R10 no clear with data present", flag_o, 1'b1);
      set_fill(0); cyc();
      check("R10 DMA drain clears", flag_o, 1'b0);
      dma_done_i = 1'b0;
   endtask

   task automatic t_new_char();
      do_reset();
      make_set();
      set_fill(3); stop_pulse();
      check("R11 new char keeps flag", flag_o, 1'b1);
      ticks(5);
      check("R11 flag stays during new idle count", flag_o, 1'b1);
   endtask

   initial begin
      #3000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_basic();
      t_restart();
      t_saturate();
      t_level();
      t_sync();
      t_sw_clear();
      t_dma();
      t_new_char();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule